// File: doc/BRIEF.md
# Factorial Compute Peripheral

This block is a small register-mapped unit that a host drives through a 32-bit read/write port with byte addresses. The host writes an operand to the value register. The unit then runs a sequential multiply loop, one multiply per clock, and leaves the factorial of the operand, truncated to 32 bits, in the same register. While the loop runs, a busy flag in the status register reads as one. A second write to the value register during that time is dropped.

When the loop finishes and the completion-interrupt enable in the status register is set, the unit sets bit 0 of an interrupt status register. The host can set any interrupt status bits through a raise register and clear them through an acknowledge register. The unit holds one level interrupt output high while any interrupt status bit is set. The bank also has an identification word and a scratch register that stores the inverse of what is written. Every access is filtered by its byte size.

Top module: `fctacc_top`

## Requirements
- R1: After reset: offset 0x00 reads the identification constant 0xFAC70100. Offsets 0x04, 0x08, 0x20 and 0x24 read 0. `irq` is low.
- R2: A 4-byte write to offset 0x04 stores the bitwise inverse of the written data. A read of 0x04 returns that stored inverse.
- R3: A 4-byte write of operand n to offset 0x08 at a clock edge sets status bit 0 (busy). For n up to 33, bit 0 stays set for exactly max(n,1) clock cycles. After that, 0x08 reads n! modulo 2^32, and operands 0 and 1 give 1.
- R4: For any operand of 34 or more, the result reads 0 because 2^32 divides the product. Busy clears within 64 cycles.
- R5: A write to 0x08 while busy is ignored: neither the running computation nor its result changes.
- R6: Status offset 0x20 holds the completion-interrupt enable in bit 7, which the host can write. Bit 0 is busy and is read-only: writing it neither starts nor stops a computation. The other bits read 0.
- R7: When busy clears with bit 7 set, bit 0 of interrupt status (0x24) is set. When busy clears with bit 7 clear, interrupt status is left unchanged.
- R8: A write to 0x60 ORs its data into interrupt status, and a write to 0x64 clears the bits that are one in its data. `irq` equals "interrupt status nonzero" and follows it in the same edge that changes the status.
- R9: Clearing status bit 7 does not clear an interrupt status bit that is already set.
- R10: If completion and an acknowledge of bit 0 hit the same edge, bit 0 ends set. Setting takes priority over clearing, so the completion event is not lost.
- R11: An access whose size is not exactly 4 bytes (`req_size` != 4) reads as 0xFFFFFFFF, and as a write it changes nothing.
- R12: Offsets 0x60, 0x64, every unaligned offset, every other unused offset, and everything from 0x80 up read as 0xFFFFFFFF. Every read yields `rsp_valid` high with data exactly one cycle after the request edge, and a write yields none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after a read request) |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | Level interrupt, high while interrupt status is nonzero |

## Verification
The two functions that can fall in the same cycle are the sequencer's completion and a host acknowledge of the completion bit. Completion lands exactly max(n,1) edges after the start write, so the bench can place the acknowledge exactly. For two operands, the bench places the acknowledge write at every offset from one edge after the start to two edges past completion. The interrupt status must still hold bit 0 when the acknowledge came at or before the completion edge, and must have dropped it when the acknowledge came later. The factorial path is swept over every operand from 0 to 40 against a product computed in the bench.

// File: rtl/fctacc_pkg.sv
package fctacc_pkg;

  localparam int unsigned OFF_ID    = 'h00;
  localparam int unsigned OFF_SCR   = 'h04;
  localparam int unsigned OFF_VAL   = 'h08;
  localparam int unsigned OFF_STAT  = 'h20;
  localparam int unsigned OFF_ISTAT = 'h24;
  localparam int unsigned OFF_RAISE = 'h60;
  localparam int unsigned OFF_ACK   = 'h64;

  localparam int unsigned STAT_BUSY_BIT = 0;
  localparam int unsigned STAT_IEN_BIT  = 7;
  localparam int unsigned IRQ_FACT_BIT  = 0;

  typedef enum logic [2:0] {
    SEL_ID, SEL_SCR, SEL_VAL, SEL_STAT,
    SEL_ISTAT, SEL_RAISE, SEL_ACK, SEL_NONE
  } sel_e;

  function automatic sel_e decode_sel(input int unsigned a);
    case (a)
      OFF_ID:    return SEL_ID;
      OFF_SCR:   return SEL_SCR;
      OFF_VAL:   return SEL_VAL;
      OFF_STAT:  return SEL_STAT;
      OFF_ISTAT: return SEL_ISTAT;
      OFF_RAISE: return SEL_RAISE;
      OFF_ACK:   return SEL_ACK;
      default:   return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/fctacc_seq.sv
module fctacc_seq #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [DATA_W-1:0] operand_i,
  output logic              busy_o,
  output logic              fin_o,
  output logic [DATA_W-1:0] value_o
);

  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] value_q;
  logic              busy_q;
  logic              last_step;

  // Stop when the down-counter reaches 1, or early once the product is 0 mod 2^DATA_W
  assign last_step = (cnt_q <= DATA_W'(1)) || (acc_q == '0);
  assign fin_o     = busy_q && last_step;
  assign busy_o    = busy_q;
  assign value_o   = value_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      acc_q   <= '0;
      cnt_q   <= '0;
      value_q <= '0;
    end else if (start_i && !busy_q) begin
      busy_q  <= 1'b1;
      acc_q   <= DATA_W'(1);
      cnt_q   <= operand_i;
      value_q <= operand_i;
    end else if (fin_o) begin
      busy_q  <= 1'b0;
      value_q <= acc_q;
    end else if (busy_q) begin
      acc_q <= acc_q * cnt_q;
      cnt_q <= cnt_q - DATA_W'(1);
    end
  end

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    start_i && !busy_o |=> busy_o); // R3
  AST_FIN_CLEARS_BUSY: assert property (@(posedge clk) disable iff (rst)
    fin_o |=> !busy_o); // R3
  AST_BUSY_NOT_DISTURBED: assert property (@(posedge clk) disable iff (rst)
    busy_o && !fin_o && start_i |=> busy_o && $stable(value_o)); // R5

endmodule

// File: rtl/fctacc_irq.sv
module fctacc_irq #(
  parameter int DATA_W   = 32,
  parameter int FACT_BIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] raise_i,
  input  logic [DATA_W-1:0] ack_i,
  input  logic              fact_i,
  output logic [DATA_W-1:0] stat_o,
  output logic              irq_o
);

  logic [DATA_W-1:0] stat_q;
  logic [DATA_W-1:0] fact_vec;
  logic [DATA_W-1:0] stat_next;

  always_comb begin
    fact_vec           = '0;
    fact_vec[FACT_BIT] = fact_i;
    // set sources win over acknowledge in the same edge
    stat_next = (stat_q & ~ack_i) | raise_i | fact_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      stat_q <= stat_next;
      irq_o  <= |stat_next;
    end
  end

  assign stat_o = stat_q;

  AST_FACT_WINS_ACK: assert property (@(posedge clk) disable iff (rst)
    fact_i |=> stat_o[FACT_BIT]); // R10
  AST_FACT_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
    fact_i |=> irq_o); // R7
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ack_i[FACT_BIT] && !fact_i && !raise_i[FACT_BIT] |=> !stat_o[FACT_BIT]); // R8

endmodule

// File: rtl/fctacc_top.sv
module fctacc_top #(
  parameter int          DATA_W     = 32,
  parameter int          ADDR_W     = 8,
  parameter int          SIZE_W     = 4,
  parameter int          WORD_BYTES = 4,
  parameter logic [31:0] ID_VALUE   = 32'hFAC7_0100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq
);
  import fctacc_pkg::*;

  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  sel_e              sel;
  logic              size_ok;
  logic              wr_ok;
  logic              start;
  logic              busy;
  logic              fin;
  logic [DATA_W-1:0] value;
  logic [DATA_W-1:0] istat;
  logic [DATA_W-1:0] raise_vec;
  logic [DATA_W-1:0] ack_vec;
  logic [DATA_W-1:0] scratch_q;
  logic              ien_q;
  logic [DATA_W-1:0] rd_mux;

  assign sel     = decode_sel(32'(req_addr));
  assign size_ok = (req_size == SIZE_W'(WORD_BYTES));
  assign wr_ok   = req_valid && req_write && size_ok;
  assign start   = wr_ok && (sel == SEL_VAL) && !busy;

  assign raise_vec = (wr_ok && sel == SEL_RAISE) ? req_wdata : '0;
  assign ack_vec   = (wr_ok && sel == SEL_ACK)   ? req_wdata : '0;

  fctacc_seq #(.DATA_W(DATA_W)) i_seq (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start),
    .operand_i (req_wdata),
    .busy_o    (busy),
    .fin_o     (fin),
    .value_o   (value)
  );

  fctacc_irq #(.DATA_W(DATA_W), .FACT_BIT(IRQ_FACT_BIT)) i_irq (
    .clk     (clk),
    .rst     (rst),
    .raise_i (raise_vec),
    .ack_i   (ack_vec),
    .fact_i  (fin && ien_q),
    .stat_o  (istat),
    .irq_o   (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      scratch_q <= '0;
      ien_q     <= 1'b0;
    end else if (wr_ok) begin
      if (sel == SEL_SCR)  scratch_q <= ~req_wdata;
      if (sel == SEL_STAT) ien_q     <= req_wdata[STAT_IEN_BIT];
    end
  end

  always_comb begin
    rd_mux = ALL_ONES;
    if (size_ok) begin
      case (sel)
        SEL_ID:    rd_mux = DATA_W'(ID_VALUE);
        SEL_SCR:   rd_mux = scratch_q;
        SEL_VAL:   rd_mux = value;
        SEL_STAT: begin
          rd_mux                = '0;
          rd_mux[STAT_BUSY_BIT] = busy;
          rd_mux[STAT_IEN_BIT]  = ien_q;
        end
        SEL_ISTAT: rd_mux = istat;
        default:   rd_mux = ALL_ONES;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write) rsp_rdata <= rd_mux;
    end
  end

  AST_READ_GETS_RSP: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_write |=> rsp_valid); // R12
  AST_WRITE_NO_RSP: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_write |=> !rsp_valid); // R12
  AST_BAD_SIZE_ONES: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_write && !size_ok |=> rsp_rdata == ALL_ONES); // R11
  AST_BAD_SIZE_NO_START: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_write && !size_ok && !busy |=> !busy); // R11

endmodule

// File: tb/test_fctacc_top.sv
module test_fctacc_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [3:0]  req_size = 4'd4;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  fctacc_top i_fctacc_top (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] sz = 4'd4);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_size = sz;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_size = 4'd4;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, input logic [3:0] sz = 4'd4);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
    @(negedge clk);
    d = rsp_rdata;
    if (rsp_valid !== 1'b1) chk("R12 rsp_valid", {31'b0, rsp_valid}, 32'd1);
    req_valid = 1'b0; req_size = 4'd4;
  endtask

  function automatic logic [31:0] fact(input logic [31:0] n);
    logic [31:0] r = 32'd1;
    if (n >= 34) return 32'd0;
    for (int i = 2; i <= int'(n); i++) r = r * 32'(i);
    return r;
  endfunction

  // count status reads with busy set, first read at edge after the start edge
  task automatic run(input logic [31:0] n, output int busy_cycles);
    logic [31:0] s;
    wr(8'h08, n);
    busy_cycles = 0;
    for (int k = 0; k < 200; k++) begin
      rd(8'h20, s);
      if (!s[0]) break;
      busy_cycles++;
    end
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int bc;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(8'h00, d); chk("R1 id", d, 32'hFAC70100);
    rd(8'h04, d); chk("R1 scratch", d, 32'h0);
    rd(8'h08, d); chk("R1 value", d, 32'h0);
    rd(8'h20, d); chk("R1 status", d, 32'h0);
    rd(8'h24, d); chk("R1 istat", d, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'd0);

    // R2 scratch inverse
    foreach (d[i]) if (i < 4) begin
      logic [31:0] v;
      logic [31:0] r;
      v = (i == 0) ? 32'h0 : (i == 1) ? 32'hFFFFFFFF : (i == 2) ? 32'h12345678 : 32'hA5A50F0F;
      wr(8'h04, v); rd(8'h04, r); chk("R2 scratch", r, ~v);
    end

    // R12 write gives no response
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h04; req_wdata = 32'h1;
    @(negedge clk);
    chk("R12 write no rsp", {31'b0, rsp_valid}, 32'd0);
    req_valid = 1'b0; req_write = 1'b0;

    // R3/R4/R7 sweep with enable set
    wr(8'h20, 32'h80);
    rd(8'h20, d); chk("R6 enable readback", d, 32'h80);
    for (int n = 0; n <= 40; n++) begin
      run(32'(n), bc);
      if (n <= 33) chk("R3 busy cycles", 32'(bc), 32'(n < 1 ? 1 : n));
      else chk("R4 busy bound", {31'b0, bc <= 64}, 32'd1);
      rd(8'h08, d); chk(n <= 33 ? "R3 result" : "R4 result", d, fact(32'(n)));
      rd(8'h24, d); chk("R7 istat set", d, 32'h1);
      chk("R8 irq high", {31'b0, irq}, 32'd1);
      wr(8'h64, 32'h1);
      chk("R8 irq low after ack", {31'b0, irq}, 32'd0);
    end

    // R4 large operands
    for (int k = 0; k < 3; k++) begin
      logic [31:0] big;
      big = (k == 0) ? 32'd100 : (k == 1) ? 32'd12345 : 32'hFFFFFFFF;
      run(big, bc);
      chk("R4 busy bound", {31'b0, bc <= 64}, 32'd1);
      rd(8'h08, d); chk("R4 result", d, 32'h0);
      wr(8'h64, 32'hFFFFFFFF);
    end

    // R5 write while busy dropped
    wr(8'h08, 32'd10);
    wr(8'h08, 32'd3);
    repeat (20) @(negedge clk);
    rd(8'h08, d); chk("R5 second start dropped", d, fact(32'd10));
    wr(8'h64, 32'hFFFFFFFF);

    // R6 busy bit read-only
    wr(8'h20, 32'h81);
    rd(8'h20, d); chk("R6 bit0 read-only", d, 32'h80);
    rd(8'h08, d); chk("R6 no start", d, fact(32'd10));
    wr(8'h08, 32'd12);
    wr(8'h20, 32'h80);
    repeat (16) @(negedge clk);
    rd(8'h08, d); chk("R6 writing status keeps run", d, fact(32'd12));
    wr(8'h64, 32'hFFFFFFFF);

    // R7 disabled: no interrupt
    wr(8'h20, 32'h0);
    run(32'd5, bc);
    rd(8'h24, d); chk("R7 disabled no istat", d, 32'h0);
    chk("R7 disabled irq", {31'b0, irq}, 32'd0);

    // R8 raise/ack
    wr(8'h60, 32'h0000_00F0);
    chk("R8 irq after raise", {31'b0, irq}, 32'd1);
    rd(8'h24, d); chk("R8 raise", d, 32'hF0);
    wr(8'h60, 32'h8000_0000);
    rd(8'h24, d); chk("R8 raise or", d, 32'h8000_00F0);
    wr(8'h64, 32'h8000_0030);
    rd(8'h24, d); chk("R8 ack partial", d, 32'hC0);
    wr(8'h64, 32'hC0);
    rd(8'h24, d); chk("R8 ack all", d, 32'h0);
    chk("R8 irq low", {31'b0, irq}, 32'd0);

    // R9 clearing enable keeps pending
    wr(8'h20, 32'h80);
    run(32'd4, bc);
    wr(8'h20, 32'h0);
    rd(8'h24, d); chk("R9 pending kept", d, 32'h1);
    chk("R9 irq kept", {31'b0, irq}, 32'd1);
    wr(8'h64, 32'hFFFFFFFF);

    // R10 completion vs acknowledge at every offset
    wr(8'h20, 32'h80);
    for (int m = 0; m < 2; m++) begin
      int n = (m == 0) ? 3 : 6;
      for (int j = 1; j <= n + 2; j++) begin
        wr(8'h08, 32'(n));
        repeat (j - 1) @(negedge clk);
        wr(8'h64, 32'h1);
        repeat (12) @(negedge clk);
        rd(8'h24, d);
        chk("R10 set beats ack", d, (j <= n) ? 32'h1 : 32'h0);
        wr(8'h64, 32'hFFFFFFFF);
      end
    end
    wr(8'h20, 32'h0);

    // R11 size filter
    for (int s = 0; s < 4; s++) begin
      logic [3:0] sz;
      sz = (s == 0) ? 4'd1 : (s == 1) ? 4'd2 : (s == 2) ? 4'd3 : 4'd8;
      rd(8'h00, d, sz); chk("R11 bad size read", d, 32'hFFFFFFFF);
      wr(8'h04, 32'h0F0F0F0F, sz);
    end
    wr(8'h04, 32'h0);
    rd(8'h04, d); chk("R11 scratch untouched", d, 32'hFFFFFFFF);
    wr(8'h04, 32'h1234, 4'd2);
    rd(8'h04, d); chk("R11 bad size write ignored", d, 32'hFFFFFFFF);
    wr(8'h08, 32'd5, 4'd8);
    rd(8'h20, d); chk("R11 no start", d, 32'h0);
    wr(8'h60, 32'h1, 4'd1);
    rd(8'h24, d); chk("R11 no raise", d, 32'h0);

    // R12 unmapped
    for (int u = 0; u < 7; u++) begin
      logic [7:0] a;
      a = (u == 0) ? 8'h0C : (u == 1) ? 8'h28 : (u == 2) ? 8'h80 :
          (u == 3) ? 8'hFC : (u == 4) ? 8'h05 : (u == 5) ? 8'h60 : 8'h64;
      rd(a, d); chk("R12 unmapped", d, 32'hFFFFFFFF);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule